// File: doc/BRIEF.md
# Shared Register and Queue Window Bridge

This block is a Wishbone slave that presents one word-addressed space to a processor-side bus master. The lower part of the space is a bank of plain read/write control registers. Above the bank, each hardware queue appears at one fixed address. A write to a downstream queue address adds a word to that queue. A read from an upstream queue address removes a word from that queue. Because a queue address never moves, a master can use constant-address bursts to stream words through it.

On the user-logic side, every downstream queue drives a valid/ready source and every upstream queue accepts a valid/ready sink. A word moves on a clock edge only when valid and ready are both high. The user logic may hold ready low for as long as it needs. A source holds its data stable while valid is high. The user logic reads the registers through a separate index/data port. Each queue also drives plain full and empty flags.

The bus acknowledge is combinational, so each beat can finish in the cycle it is presented. A beat that cannot complete is held by keeping the acknowledge low: a write to a full downstream queue, or a read from an empty upstream queue. The beat finishes in the first cycle in which the condition clears.

Top module: `wb_window_bridge`

## Requirements
- R1: A synchronous reset clears every register to zero and empties every queue. After reset, no downstream queue is valid, and every upstream queue is ready and empty.
- R2: Word offsets 0x000 to 0x1FF select registers 0 to 511. A write stores the data and a read returns the stored word. Such beats are acknowledged in the cycle they are presented and never stall.
- R3: The user register port returns the register chosen by its index in the same cycle, including a value written on the bus in an earlier cycle.
- R4: An acknowledged write to offset 0x200+k (k from 0 to 4) appends the word to downstream queue k. Downstream queue k presents its words in arrival order on its 32-bit data slice, bits [32k+31:32k]. Valid stays high while the queue is not empty, and the head is removed on a clock edge where valid and ready are both high.
- R5: Each downstream queue holds 16 words and raises its full flag at 16. A write to a full queue keeps ACK low until the user removes a word, then completes in the next cycle.
- R6: An acknowledged read from offset 0x205+k (k from 0 to 3) returns and removes the oldest word of upstream queue k. Words pushed on the 32-bit slice [32k+31:32k] come back in arrival order.
- R7: Each upstream queue holds 16 words. Its ready output is low while it is full. A read from an empty upstream queue keeps ACK low until the user pushes a word, and then returns that word.
- R8: Reads from downstream queue addresses and writes to upstream queue addresses are acknowledged at once and change no queue. Those reads return zero.
- R9: Offsets from 0x209 upward are acknowledged at once. Reads there return zero and writes there change no register or queue.
- R10: Back-to-back beats of a burst at one queue address, with strobe held high, each move exactly one word.
- R11: ACK is never high unless cycle and strobe are both high. Read data is zero in any cycle that is not an acknowledged read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and user clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle active |
| stb_i | input | 1 | Beat strobe |
| we_i | input | 1 | 1 = write beat, 0 = read beat |
| adr_i | input | 12 | Word offset |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data |
| ack_o | output | 1 | Beat acknowledge |
| ureg_idx | input | 9 | User register read index |
| ureg_data | output | 32 | User register read data |
| down_valid | output | 5 | Downstream queue has a word, one bit per queue |
| down_ready | input | 5 | User takes the head word |
| down_data | output | 160 | Head words, 32 bits per queue |
| down_full | output | 5 | Downstream queue holds 16 words |
| down_empty | output | 5 | Downstream queue holds nothing |
| up_valid | input | 4 | User offers a word, one bit per queue |
| up_ready | output | 4 | Upstream queue can accept a word |
| up_data | input | 128 | Offered words, 32 bits per queue |
| up_full | output | 4 | Upstream queue holds 16 words |
| up_empty | output | 4 | Upstream queue holds nothing |

## Verification
The assertions assume the master keeps the address, write flag and data of a stalled beat stable until ACK. They also assume reset is held for at least one clock edge before the first beat. The user side is assumed to keep valid and data stable until ready, though the properties rely only on the handshake at each edge. The bench drives every input half a period away from the rising edge, keeps each beat's fields fixed until it sees ACK, and changes them only after the edge that accepts the beat. It issues random traffic only when its model says the beat cannot stall, so stalls come only from the directed cases built for them.

// File: rtl/wbw_pkg.sv
`timescale 1ns/1ps
package wbw_pkg;
  typedef enum logic [1:0] {RGN_REG, RGN_DOWN, RGN_UP, RGN_HOLE} region_e;
endpackage

// File: rtl/wbw_decode.sv
`timescale 1ns/1ps
module wbw_decode #(
  parameter int AW    = 12,
  parameter int NREG  = 512,
  parameter int NDOWN = 5,
  parameter int NUP   = 4,
  localparam int RIW  = $clog2(NREG),
  localparam int QIW  = $clog2((NDOWN > NUP) ? NDOWN : NUP)
) (
  input  logic [AW-1:0]      adr,
  output wbw_pkg::region_e   region,
  output logic [RIW-1:0]     reg_idx,
  output logic [QIW-1:0]     q_idx
);
  localparam logic [AW-1:0] DOWN_BASE = AW'(NREG);
  localparam logic [AW-1:0] UP_BASE   = AW'(NREG + NDOWN);
  localparam logic [AW-1:0] SPAN_END  = AW'(NREG + NDOWN + NUP);

  assign reg_idx = adr[RIW-1:0];

  always_comb begin
    region = wbw_pkg::RGN_HOLE;
    q_idx  = '0;
    if (adr < DOWN_BASE) begin
      region = wbw_pkg::RGN_REG;
    end else if (adr < UP_BASE) begin
      region = wbw_pkg::RGN_DOWN;
      q_idx  = QIW'(adr - DOWN_BASE);
    end else if (adr < SPAN_END) begin
      region = wbw_pkg::RGN_UP;
      q_idx  = QIW'(adr - UP_BASE);
    end
  end
endmodule

// File: rtl/wbw_regbank.sv
`timescale 1ns/1ps
module wbw_regbank #(
  parameter int DW   = 32,
  parameter int NREG = 512,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [RIW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic [RIW-1:0] rd_idx,
  output logic [DW-1:0]  rd_data,
  input  logic [RIW-1:0] usr_idx,
  output logic [DW-1:0]  usr_data
);
  logic [DW-1:0] bank [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (wr_en) begin
      bank[wr_idx] <= wr_data;
    end
  end

  assign rd_data  = bank[rd_idx];
  assign usr_data = bank[usr_idx];
endmodule

// File: rtl/wbw_queue.sv
`timescale 1ns/1ps
module wbw_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW:0]   wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push && !full) begin
        mem[wr_ptr[PW-1:0]] <= push_data;
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
  assign head  = mem[rd_ptr[PW-1:0]];
endmodule

// File: rtl/wb_window_bridge.sv
`timescale 1ns/1ps
module wb_window_bridge #(
  parameter int DW     = 32,
  parameter int AW     = 12,
  parameter int NREG   = 512,
  parameter int NDOWN  = 5,
  parameter int NUP    = 4,
  parameter int QDEPTH = 16,
  localparam int RIW   = $clog2(NREG),
  localparam int QIW   = $clog2((NDOWN > NUP) ? NDOWN : NUP)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [AW-1:0]     adr_i,
  input  logic [DW-1:0]     dat_i,
  output logic [DW-1:0]     dat_o,
  output logic              ack_o,
  input  logic [RIW-1:0]    ureg_idx,
  output logic [DW-1:0]     ureg_data,
  output logic [NDOWN-1:0]  down_valid,
  input  logic [NDOWN-1:0]  down_ready,
  output logic [NDOWN*DW-1:0] down_data,
  output logic [NDOWN-1:0]  down_full,
  output logic [NDOWN-1:0]  down_empty,
  input  logic [NUP-1:0]    up_valid,
  output logic [NUP-1:0]    up_ready,
  input  logic [NUP*DW-1:0] up_data,
  output logic [NUP-1:0]    up_full,
  output logic [NUP-1:0]    up_empty
);
  wbw_pkg::region_e region;
  logic [RIW-1:0]   reg_idx;
  logic [QIW-1:0]   q_idx;
  logic [DW-1:0]    reg_rd;
  logic             reg_we;
  logic [NDOWN-1:0] down_push;
  logic [NUP-1:0]   up_pop;
  logic [DW-1:0]    up_head [NUP];
  logic [DW-1:0]    rdat;
  logic             hit;

  wbw_decode #(.AW(AW), .NREG(NREG), .NDOWN(NDOWN), .NUP(NUP)) u_decode (
    .adr(adr_i), .region(region), .reg_idx(reg_idx), .q_idx(q_idx)
  );

  wbw_regbank #(.DW(DW), .NREG(NREG)) u_regs (
    .clk(clk_i), .rst(rst_i), .wr_en(reg_we), .wr_idx(reg_idx), .wr_data(dat_i),
    .rd_idx(reg_idx), .rd_data(reg_rd), .usr_idx(ureg_idx), .usr_data(ureg_data)
  );

  for (genvar k = 0; k < NDOWN; k++) begin : g_down
    wbw_queue #(.DW(DW), .DEPTH(QDEPTH)) u_q (
      .clk(clk_i), .rst(rst_i),
      .push(down_push[k]), .push_data(dat_i),
      .pop(down_ready[k]), .head(down_data[k*DW +: DW]),
      .full(down_full[k]), .empty(down_empty[k])
    );
    assign down_valid[k] = !down_empty[k];
  end

  for (genvar k = 0; k < NUP; k++) begin : g_up
    wbw_queue #(.DW(DW), .DEPTH(QDEPTH)) u_q (
      .clk(clk_i), .rst(rst_i),
      .push(up_valid[k]), .push_data(up_data[k*DW +: DW]),
      .pop(up_pop[k]), .head(up_head[k]),
      .full(up_full[k]), .empty(up_empty[k])
    );
    assign up_ready[k] = !up_full[k];
  end

  assign hit = cyc_i && stb_i;

  always_comb begin
    ack_o     = 1'b0;
    rdat      = '0;
    reg_we    = 1'b0;
    down_push = '0;
    up_pop    = '0;
    case (region)
      wbw_pkg::RGN_REG: begin
        ack_o  = hit;
        reg_we = hit && we_i;
        rdat   = reg_rd;
      end
      wbw_pkg::RGN_DOWN: begin
        if (we_i) begin
          ack_o            = hit && !down_full[q_idx];
          down_push[q_idx] = ack_o;
        end else begin
          ack_o = hit;
        end
      end
      wbw_pkg::RGN_UP: begin
        if (we_i) begin
          ack_o = hit;
        end else begin
          ack_o         = hit && !up_empty[q_idx];
          up_pop[q_idx] = ack_o;
          rdat          = up_head[q_idx];
        end
      end
      default: ack_o = hit;
    endcase
  end

  assign dat_o = (ack_o && !we_i) ? rdat : '0;
endmodule

// File: rtl/wb_window_bridge_chk.sv
`timescale 1ns/1ps
module wb_window_bridge_chk #(
  parameter int DW     = 32,
  parameter int AW     = 12,
  parameter int NREG   = 512,
  parameter int NDOWN  = 5,
  parameter int NUP    = 4
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              cyc_i,
  input logic              stb_i,
  input logic              we_i,
  input logic [AW-1:0]     adr_i,
  input logic [DW-1:0]     dat_o,
  input logic              ack_o,
  input logic [NDOWN-1:0]  down_valid,
  input logic [NDOWN-1:0]  down_full,
  input logic [NUP-1:0]    up_full,
  input logic [NUP-1:0]    up_empty
);
  localparam logic [AW-1:0] SPAN_END = AW'(NREG + NDOWN + NUP);

  // R11
  ack_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |-> (cyc_i && stb_i));

  // R11
  quiet_data_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(ack_o && !we_i) |-> (dat_o == '0));

  // R2
  reg_no_stall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cyc_i && stb_i && adr_i < AW'(NREG)) |-> ack_o);

  // R9
  hole_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cyc_i && stb_i && adr_i >= SPAN_END) |-> (ack_o && dat_o == '0));

  for (genvar k = 0; k < NDOWN; k++) begin : g_dchk
    // R5
    full_stall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc_i && stb_i && we_i && adr_i == AW'(NREG + k) && down_full[k]) |-> !ack_o);
    // R4
    push_lands_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (ack_o && we_i && adr_i == AW'(NREG + k)) |=> down_valid[k]);
  end

  for (genvar k = 0; k < NUP; k++) begin : g_uchk
    // R7
    empty_stall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc_i && stb_i && !we_i && adr_i == AW'(NREG + NDOWN + k) && up_empty[k]) |-> !ack_o);
    // R6
    pop_frees_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (ack_o && !we_i && adr_i == AW'(NREG + NDOWN + k)) |=> !up_full[k]);
    // R8
    up_write_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc_i && stb_i && we_i && adr_i == AW'(NREG + NDOWN + k)) |-> ack_o);
  end
endmodule

bind wb_window_bridge wb_window_bridge_chk #(
  .DW(DW), .AW(AW), .NREG(NREG), .NDOWN(NDOWN), .NUP(NUP)
) i_chk (.*);

// File: tb/test_wb_window_bridge.sv
`timescale 1ns/1ps
module test_wb_window_bridge;
  localparam int DW = 32, AW = 12, NREG = 512, ND = 5, NU = 4, QD = 16;
  localparam int DBASE = 512, UBASE = 517;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic cyc_i = 0, stb_i = 0, we_i = 0;
  logic [AW-1:0] adr_i = '0;
  logic [DW-1:0] dat_i = '0;
  logic [DW-1:0] dat_o;
  logic ack_o;
  logic [8:0] ureg_idx = '0;
  logic [DW-1:0] ureg_data;
  logic [ND-1:0] down_valid, down_full, down_empty;
  logic [ND-1:0] down_ready = '0;
  logic [ND*DW-1:0] down_data;
  logic [NU-1:0] up_valid = '0;
  logic [NU-1:0] up_ready, up_full, up_empty;
  logic [NU*DW-1:0] up_data = '0;

  always #4 clk = ~clk;

  wb_window_bridge i_wb_window_bridge (
    .clk_i(clk), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o),
    .ureg_idx(ureg_idx), .ureg_data(ureg_data),
    .down_valid(down_valid), .down_ready(down_ready), .down_data(down_data),
    .down_full(down_full), .down_empty(down_empty),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .up_full(up_full), .up_empty(up_empty)
  );

  int runs = 0, fails = 0;
  logic [DW-1:0] regm [NREG];
  logic [DW-1:0] dq [ND][$];
  logic [DW-1:0] uq [NU][$];

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd();
    return $urandom();
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) regm[i] = '0;
    for (int i = 0; i < ND; i++) dq[i].delete();
    for (int i = 0; i < NU; i++) uq[i].delete();
  endtask

  // one bus beat; hold keeps strobe high afterwards for a burst
  task automatic beat(input bit wr, input int adr, input logic [DW-1:0] wd,
                      output logic [DW-1:0] rd, input bit hold);
    bit got = 0;
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = wr; adr_i = AW'(adr); dat_i = wd;
    for (int n = 0; n < 200; n++) begin
      #1;
      if (ack_o) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R11 beat acknowledged", 32'(got), 32'd1);
    rd = dat_o;
    @(posedge clk); #1;
    if (!hold) begin cyc_i = 0; stb_i = 0; we_i = 0; end
  endtask

  task automatic pop_down(input int k, input string req);
    logic [DW-1:0] e;
    @(negedge clk); #1;
    chk(down_valid[k] == (dq[k].size() != 0), req, 32'(down_valid[k]), 32'(dq[k].size() != 0));
    if (dq[k].size() != 0) begin
      e = dq[k].pop_front();
      chk(down_data[k*DW +: DW] == e, req, down_data[k*DW +: DW], e);
    end
    down_ready[k] = 1;
    @(posedge clk); #1;
    down_ready[k] = 0;
  endtask

  task automatic push_up(input int k, input logic [DW-1:0] d, input string req);
    @(negedge clk);
    up_valid[k] = 1; up_data[k*DW +: DW] = d;
    #1;
    chk(up_ready[k] == (uq[k].size() < QD), req, 32'(up_ready[k]), 32'(uq[k].size() < QD));
    if (uq[k].size() < QD) uq[k].push_back(d);
    @(posedge clk); #1;
    up_valid[k] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_i = 1;
    repeat (2) @(negedge clk);
    rst_i = 0;
    model_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd, v;
    void'($urandom(32'd7319));
    model_reset();
    repeat (3) @(negedge clk);
    rst_i = 0;

    // R1 reset state after dirtying state
    beat(1, 7, 32'hA5A5_0007, rd, 0);
    beat(1, DBASE + 1, 32'h1111_0001, rd, 0);
    push_up(2, 32'h2222_0002, "R1 setup push");
    do_reset();
    #1;
    chk(down_valid == '0, "R1 downstream invalid", 32'(down_valid), 0);
    chk(up_ready == '1 && up_empty == '1, "R1 upstream ready/empty", 32'({up_ready, up_empty}), 32'hFF);
    ureg_idx = 9'd7; #1;
    chk(ureg_data == 0, "R1 register cleared", ureg_data, 0);

    // R2 / R3 boundary registers
    beat(1, 0, 32'hDEAD_0000, rd, 0); regm[0] = 32'hDEAD_0000;
    beat(1, 511, 32'hBEEF_01FF, rd, 0); regm[511] = 32'hBEEF_01FF;
    beat(0, 511, 0, rd, 0);
    chk(rd == regm[511], "R2 read reg 511", rd, regm[511]);
    beat(0, 0, 0, rd, 0);
    chk(rd == regm[0], "R2 read reg 0", rd, regm[0]);
    ureg_idx = 9'd511; #1;
    chk(ureg_data == regm[511], "R3 user port reg 511", ureg_data, regm[511]);

    // R9 unmapped
    beat(1, 12'h209, 32'h5555_5555, rd, 0);
    beat(1, 12'hFFF, 32'h6666_6666, rd, 0);
    beat(0, 12'h209, 0, rd, 0);
    chk(rd == 0, "R9 unmapped read zero", rd, 0);
    beat(0, 9, 0, rd, 0);
    chk(rd == regm[9], "R9 write left reg 9", rd, regm[9]);
    beat(0, 511, 0, rd, 0);
    chk(rd == regm[511], "R9 write left reg 511", rd, regm[511]);

    // R8 cross-direction accesses
    beat(1, DBASE + 3, 32'h3333_0003, rd, 0); dq[3].push_back(32'h3333_0003);
    beat(0, DBASE + 3, 0, rd, 0);
    chk(rd == 0, "R8 downstream read zero", rd, 0);
    beat(1, UBASE + 0, 32'h7777_7777, rd, 0);
    #1;
    chk(up_empty[0] == 1, "R8 upstream write no push", 32'(up_empty[0]), 1);
    pop_down(3, "R8 downstream entry intact");
    #1;
    chk(down_valid[3] == 0, "R8 one entry only", 32'(down_valid[3]), 0);

    // R10 downstream burst
    for (int i = 0; i < 6; i++) begin
      v = rnd(); beat(1, DBASE + 1, v, rd, 1); dq[1].push_back(v);
    end
    @(negedge clk); cyc_i = 0; stb_i = 0;
    for (int i = 0; i < 6; i++) pop_down(1, "R10 burst word order");
    #1;
    chk(down_valid[1] == 0, "R10 burst count exact", 32'(down_valid[1]), 0);

    // R5 full stall
    for (int i = 0; i < QD; i++) begin
      v = rnd(); beat(1, DBASE + 0, v, rd, 0); dq[0].push_back(v);
    end
    #1;
    chk(down_full[0] == 1, "R5 full flag", 32'(down_full[0]), 1);
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = 1; adr_i = AW'(DBASE); dat_i = 32'hF00D_0017;
    #1; chk(ack_o == 0, "R5 stall while full", 32'(ack_o), 0);
    @(negedge clk); #1; chk(ack_o == 0, "R5 stall held", 32'(ack_o), 0);
    v = dq[0].pop_front();
    chk(down_data[31:0] == v, "R4 head while full", down_data[31:0], v);
    down_ready[0] = 1;
    @(posedge clk); #1; down_ready[0] = 0;
    @(negedge clk); #1;
    chk(ack_o == 1, "R5 resumes after space", 32'(ack_o), 1);
    dq[0].push_back(32'hF00D_0017);
    @(posedge clk); #1; cyc_i = 0; stb_i = 0;
    for (int i = 0; i < QD; i++) pop_down(0, "R4 drain order");

    // R7 empty stall
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = 0; adr_i = AW'(UBASE + 3);
    #1; chk(ack_o == 0, "R7 stall while empty", 32'(ack_o), 0);
    @(negedge clk); #1; chk(ack_o == 0, "R7 stall held", 32'(ack_o), 0);
    up_valid[3] = 1; up_data[3*DW +: DW] = 32'hCAFE_0003;
    @(posedge clk); #1; up_valid[3] = 0;
    #1;
    chk(ack_o == 1, "R7 resumes on data", 32'(ack_o), 1);
    chk(dat_o == 32'hCAFE_0003, "R7 returns arrived word", dat_o, 32'hCAFE_0003);
    @(posedge clk); #1; cyc_i = 0; stb_i = 0;
    #1; chk(up_empty[3] == 1, "R6 pop removed word", 32'(up_empty[3]), 1);

    // R7 full upstream / R6 order
    for (int i = 0; i < QD; i++) push_up(1, rnd(), "R7 ready before full");
    #1;
    chk(up_ready[1] == 0 && up_full[1] == 1, "R7 ready low at full", 32'(up_ready[1]), 0);
    push_up(1, 32'hBAD0_BAD0, "R7 push refused");
    for (int i = 0; i < 10; i++) begin
      v = uq[1].pop_front(); beat(0, UBASE + 1, 0, rd, 1);
      chk(rd == v, "R6 R10 burst read order", rd, v);
    end
    @(negedge clk); cyc_i = 0; stb_i = 0;
    for (int i = 0; i < 6; i++) begin
      v = uq[1].pop_front(); beat(0, UBASE + 1, 0, rd, 0);
      chk(rd == v, "R6 read order", rd, v);
    end
    #1; chk(up_empty[1] == 1, "R6 drained", 32'(up_empty[1]), 1);

    // random mix that never stalls
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 6);
      int k;
      case (op)
        0: begin k = $urandom_range(0, NREG-1); v = rnd(); beat(1, k, v, rd, 0); regm[k] = v; end
        1: begin k = $urandom_range(0, NREG-1); beat(0, k, 0, rd, 0);
                 chk(rd == regm[k], "R2 random register", rd, regm[k]); end
        2: begin k = $urandom_range(0, ND-1);
                 if (dq[k].size() < QD) begin v = rnd(); beat(1, DBASE + k, v, rd, 0); dq[k].push_back(v); end end
        3: begin k = $urandom_range(0, ND-1); pop_down(k, "R4 random downstream"); end
        4: begin k = $urandom_range(0, NU-1); push_up(k, rnd(), "R7 random upstream ready"); end
        5: begin k = $urandom_range(0, NU-1);
                 if (uq[k].size() != 0) begin v = uq[k].pop_front(); beat(0, UBASE + k, 0, rd, 0);
                   chk(rd == v, "R6 random upstream", rd, v); end end
        default: begin k = $urandom_range(0, NREG-1); ureg_idx = 9'(k); #1;
                 chk(ureg_data == regm[k], "R3 random user port", ureg_data, regm[k]); end
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule